// File: doc/BRIEF.md
# Radio Frame Column Interleaver

This block reorders a block of transport-channel symbols across the radio frames of one transmission interval. The interval can last 10, 20, 40 or 80 ms. A block of a configured length arrives on a valid/ready input stream and is stored in order. Once the block is complete, it streams out on a valid/ready output stream in permuted order. The same hardware can run in reverse: in that direction it restores the original order from an interleaved block.

The symbols are viewed as a matrix of R rows by C columns. C comes from the interval length, and R is the block length divided by C. Input symbol k sits at row k/C and column k mod C. Columns are visited in bit-reversed order. The forward direction reads column by column, and the inverse direction reads row by row.

Storage is split into two halves. One block can be written while the previous one is read out. The span, direction and length are captured with the first symbol of each block and stay attached to that block until its last output symbol. A block whose configuration is unusable is thrown away and a sticky error flag is set.

Top module: `rfcol_interleaver`

## Requirements
- R1: `cfg_span` selects the column count C: 10 gives 1, 20 gives 2, 40 gives 4 and 80 gives 8. Every other value is unsupported.
- R2: With C = 1 the block is emitted unchanged and in arrival order, in both directions.
- R3: In the forward direction, for each column slot p from 0 to C-1, and within that for each row j from 0 to R-1, the output is stored symbol C*j + P[p]. P is the bit reversal of p over log2(C) bits: (0,1) for 2, (0,2,1,3) for 4, (0,4,2,6,1,5,3,7) for 8.
- R4: In the inverse direction, for each row i from 0 to R-1, and within that for each column slot q from 0 to C-1, the output is stored symbol R*P[q] + i.
- R5: `cfg_dir` = 2'b01 selects forward and `cfg_dir` = 2'b11 selects inverse. The codes 2'b00 and 2'b10 are unsupported.
- R6: `out_valid` stays low until every symbol of a block has been accepted.
- R7: If the configuration is unsupported when a block's first symbol is accepted, that symbol is consumed and discarded, no output results, and `cfg_error` goes high and stays high until reset.
- R8: A block length is valid only if it is nonzero, a multiple of C and at most MAX_LEN. Any other length is treated as in R7.
- R9: A new block can be accepted while the previous one is being read. `in_ready` is low only while two complete blocks are waiting or being read.
- R10: `out_last` is high with the final output symbol of each block and with no other symbol.
- R11: The span, direction and length seen with a block's first accepted symbol govern the whole block. Changes on those ports while the block is in progress have no effect on it.
- R12: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R13: After reset, `in_ready` is 1, `out_valid` is 0 and `cfg_error` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_span | input | 7 | Interval length in ms (10/20/40/80) |
| cfg_dir | input | 2 | 2'b01 forward, 2'b11 inverse |
| cfg_len | input | $clog2(MAX_LEN+1) | Symbols per block |
| in_valid | input | 1 | Input symbol valid |
| in_ready | output | 1 | Input symbol can be taken |
| in_data | input | DATA_W | Input symbol |
| out_valid | output | 1 | Output symbol valid |
| out_ready | input | 1 | Output symbol taken |
| out_data | output | DATA_W | Output symbol |
| out_last | output | 1 | Final symbol of a block |
| cfg_error | output | 1 | Sticky unsupported-configuration flag |

## Verification
The bench covers each column count in both directions, and the largest block at eight columns. A wrong bit-reversal table would then swap whole column groups, and a rows/columns mix-up in the inverse address would read past the row count. It changes the configuration ports in the middle of a block. A design that re-samples them would cut the block short or reorder it with the wrong column count. Back-pressure combined with back-to-back blocks exposes a half-swap or full-flag bug, which would show up as a duplicated block, a lost block or an early `out_valid`. Each kind of invalid setting is sent after a fresh reset, so a design that let any of them through would produce output or leave `cfg_error` low.

// File: rtl/rfcol_pkg.sv
`timescale 1ns/1ps
package rfcol_pkg;
   localparam logic [1:0] DIR_FWD = 2'b01;
   localparam logic [1:0] DIR_INV = 2'b11;

   typedef struct packed {
      logic [1:0] lc;   // log2 of column count
      logic       inv;  // 1: inverse direction
   } rfcol_mode_t;

   // bit reversal of a column slot over lc bits (lc <= 3)
   function automatic logic [2:0] col_rev(input logic [2:0] p, input logic [1:0] lc);
      logic [2:0] r;
      r = {p[0], p[1], p[2]};
      return r >> (2'd3 - lc);
   endfunction
endpackage

// File: rtl/rfcol_cfg_check.sv
`timescale 1ns/1ps
module rfcol_cfg_check
   import rfcol_pkg::*;
#(
   parameter int MAX_LEN = 64,
   parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
   input  logic [6:0]       span,
   input  logic [1:0]       dir,
   input  logic [LEN_W-1:0] len,
   output rfcol_mode_t      mode,
   output logic             ok
);
   logic       span_ok;
   logic       dir_ok;
   logic       len_ok;
   logic [2:0] col_mask;

   always_comb begin
      span_ok = 1'b1;
      mode.lc = 2'd0;
      case (span)
         7'd10:   mode.lc = 2'd0;
         7'd20:   mode.lc = 2'd1;
         7'd40:   mode.lc = 2'd2;
         7'd80:   mode.lc = 2'd3;
         default: span_ok = 1'b0;
      endcase
      mode.inv = (dir == DIR_INV);
      dir_ok   = (dir == DIR_FWD) || (dir == DIR_INV);
      col_mask = 3'((4'd1 << mode.lc) - 4'd1);
      len_ok   = (len != '0) && (int'(len) <= MAX_LEN) && ((len[2:0] & col_mask) == 3'd0);
      ok       = span_ok && dir_ok && len_ok;
   end
endmodule

// File: rtl/rfcol_addr_gen.sv
`timescale 1ns/1ps
module rfcol_addr_gen
   import rfcol_pkg::*;
#(
   parameter int MAX_LEN = 64,
   parameter int LEN_W   = $clog2(MAX_LEN + 1),
   parameter int AW      = $clog2(MAX_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  rfcol_mode_t      mode,
   input  logic [LEN_W-1:0] len,
   input  logic             step,
   output logic [AW-1:0]    addr,
   output logic             last
);
   logic [LEN_W-1:0] outer, inner;
   logic [LEN_W-1:0] rows, cols, outer_lim, inner_lim;
   logic [LEN_W-1:0] a_fwd, a_inv, a_sel;
   logic             inner_end;

   assign rows      = len >> mode.lc;
   assign cols      = LEN_W'(1) << mode.lc;
   assign outer_lim = mode.inv ? rows : cols;
   assign inner_lim = mode.inv ? cols : rows;
   assign inner_end = (inner == inner_lim - 1'b1);
   assign last      = inner_end && (outer == outer_lim - 1'b1);

   // forward: outer = column slot, inner = row
   assign a_fwd = LEN_W'(inner << mode.lc) + LEN_W'(col_rev(outer[2:0], mode.lc));
   // inverse: outer = row, inner = column slot
   assign a_inv = LEN_W'(rows * LEN_W'(col_rev(inner[2:0], mode.lc))) + outer;
   assign a_sel = mode.inv ? a_inv : a_fwd;
   assign addr  = a_sel[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outer <= '0;
         inner <= '0;
      end else if (step) begin
         if (inner_end) begin
            inner <= '0;
            outer <= last ? '0 : outer + 1'b1;
         end else begin
            inner <= inner + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rfcol_buf.sv
`timescale 1ns/1ps
module rfcol_buf #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   parameter int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic              wr_half,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_half,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] half_q [2];

   for (genvar h = 0; h < 2; h++) begin : g_half
      logic [DATA_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (we && (wr_half == 1'(h))) mem[wr_addr] <= wr_data;
      end
      assign half_q[h] = mem[rd_addr];
   end

   assign rd_data = half_q[rd_half];
endmodule

// File: rtl/rfcol_interleaver.sv
`timescale 1ns/1ps
module rfcol_interleaver
   import rfcol_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int MAX_LEN = 64,
   localparam int LEN_W  = $clog2(MAX_LEN + 1),
   localparam int AW     = $clog2(MAX_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [6:0]        cfg_span,
   input  logic [1:0]        cfg_dir,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last,
   output logic              cfg_error
);
   if (MAX_LEN < 8 || (MAX_LEN % 8) != 0) begin : g_chk_len
      $error("MAX_LEN must be a positive multiple of 8");
   end
   if (DATA_W < 1) begin : g_chk_w
      $error("DATA_W must be at least 1");
   end

   rfcol_mode_t      port_mode;
   logic             port_ok;
   rfcol_mode_t      mode_q [2];
   logic [LEN_W-1:0] len_q  [2];
   logic [1:0]       half_full;
   logic             wr_half, rd_half;
   logic [LEN_W-1:0] wr_idx, wr_len;
   logic             accept, first, drop, we, done, pop;
   logic [AW-1:0]    rd_addr;
   logic             blk_last;

   rfcol_cfg_check #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_cfg (
      .span(cfg_span), .dir(cfg_dir), .len(cfg_len), .mode(port_mode), .ok(port_ok)
   );

   assign in_ready = !half_full[wr_half];
   assign accept   = in_valid && in_ready;
   assign first    = (wr_idx == '0);
   assign drop     = accept && first && !port_ok;
   assign we       = accept && !drop;
   assign wr_len   = first ? cfg_len : len_q[wr_half];
   assign done     = we && (wr_idx == wr_len - 1'b1);

   assign out_valid = half_full[rd_half];
   assign pop       = out_valid && out_ready;
   assign out_last  = out_valid && blk_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_half   <= 1'b0;
         rd_half   <= 1'b0;
         wr_idx    <= '0;
         half_full <= '0;
         cfg_error <= 1'b0;
         for (int h = 0; h < 2; h++) begin
            mode_q[h] <= '0;
            len_q[h]  <= '0;
         end
      end else begin
         if (drop) cfg_error <= 1'b1;
         if (we && first) begin
            mode_q[wr_half] <= port_mode;
            len_q[wr_half]  <= cfg_len;
         end
         if (we) wr_idx <= done ? '0 : wr_idx + 1'b1;
         if (done) begin
            half_full[wr_half] <= 1'b1;
            wr_half            <= !wr_half;
         end
         if (pop && blk_last) begin
            half_full[rd_half] <= 1'b0;
            rd_half            <= !rd_half;
         end
      end
   end

   rfcol_addr_gen #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .AW(AW)) u_agen (
      .clk(clk), .rst_n(rst_n), .mode(mode_q[rd_half]), .len(len_q[rd_half]),
      .step(pop), .addr(rd_addr), .last(blk_last)
   );

   rfcol_buf #(.DATA_W(DATA_W), .DEPTH(MAX_LEN), .AW(AW)) u_buf (
      .clk(clk), .we(we), .wr_half(wr_half), .wr_addr(wr_idx[AW-1:0]), .wr_data(in_data),
      .rd_half(rd_half), .rd_addr(rd_addr), .rd_data(out_data)
   );
endmodule

// File: rtl/rfcol_checker.sv
`timescale 1ns/1ps
module rfcol_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data,
   input logic              out_last,
   input logic              cfg_error,
   input logic [1:0]        half_full
);
   logic [31:0] n_in, n_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_in  <= '0;
         n_out <= '0;
      end else begin
         if (in_valid && in_ready)   n_in  <= n_in + 1;
         if (out_valid && out_ready) n_out <= n_out + 1;
      end
   end

   assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

   assert_sticky_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_error |=> cfg_error);

   assert_error_on_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_error) |-> $past(in_valid && in_ready));

   assert_last_qualified_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   assert_ready_two_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready == !(&half_full));

   assert_no_early_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
      n_out <= n_in);
endmodule

bind rfcol_interleaver rfcol_checker #(.DATA_W(DATA_W)) u_rfcol_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
   .out_last(out_last), .cfg_error(cfg_error), .half_full(half_full)
);

// File: tb/tb_rfcol_interleaver.sv
`timescale 1ns/1ps
module tb_rfcol_interleaver;
   localparam int DATA_W  = 8;
   localparam int MAX_LEN = 64;
   localparam int LEN_W   = $clog2(MAX_LEN + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [6:0]        cfg_span = 7'd10;
   logic [1:0]        cfg_dir = 2'b01;
   logic [LEN_W-1:0]  cfg_len = '0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [DATA_W-1:0] in_data = '0;
   logic              out_valid;
   logic              out_ready = 1'b1;
   logic [DATA_W-1:0] out_data;
   logic              out_last;
   logic              cfg_error;

   int    n_vec = 0;
   int    n_bad = 0;
   string cur_req = "R13";
   bit    bp_mode = 1'b0;
   bit    finished = 1'b0;

   always #2 clk = ~clk;  // 250 MHz

   rfcol_interleaver #(.DATA_W(DATA_W), .MAX_LEN(MAX_LEN)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_span(cfg_span), .cfg_dir(cfg_dir), .cfg_len(cfg_len),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_last(out_last), .cfg_error(cfg_error)
   );

   // ---------------- behavioural reference model ----------------
   int m_in_buf[$];
   int m_out_q[$];   // bit 16 marks block end
   int m_nblk = 0;
   int m_cols = 1;
   int m_inv  = 0;
   int m_len  = 0;
   bit m_err  = 0;

   function automatic int perm(input int c, input int p);
      int t4[4] = '{0, 2, 1, 3};
      int t8[8] = '{0, 4, 2, 6, 1, 5, 3, 7};
      if (c == 8) return t8[p];
      if (c == 4) return t4[p];
      return p;  // 1 or 2 columns: identity
   endfunction

   function automatic int span_cols(input int s);
      case (s)
         10: return 1;
         20: return 2;
         40: return 4;
         80: return 8;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_in_buf.delete();
         m_out_q.delete();
         m_nblk = 0;
         m_err  = 0;
      end else begin
         bit rdy, vld;
         int e;
         rdy = (m_nblk < 2);
         vld = (m_nblk > 0);
         if (vld && out_ready) begin
            e = m_out_q.pop_front();
            if (e[16]) m_nblk--;
         end
         if (in_valid && rdy) begin
            bit keep;
            keep = 1'b1;
            if (m_in_buf.size() == 0) begin
               int c;
               c = span_cols(int'(cfg_span));
               if (c == 0 || !(cfg_dir == 2'b01 || cfg_dir == 2'b11) || cfg_len == 0 ||
                   int'(cfg_len) > MAX_LEN || (int'(cfg_len) % c) != 0) begin
                  m_err = 1;
                  keep  = 1'b0;
               end else begin
                  m_cols = c;
                  m_inv  = (cfg_dir == 2'b11);
                  m_len  = int'(cfg_len);
               end
            end
            if (keep) begin
               m_in_buf.push_back(int'(in_data));
               if (m_in_buf.size() == m_len) begin
                  int r, n, v;
                  r = m_len / m_cols;
                  n = 0;
                  if (!m_inv) begin
                     for (int p = 0; p < m_cols; p++)
                        for (int j = 0; j < r; j++) begin
                           n++;
                           v = m_in_buf[m_cols * j + perm(m_cols, p)];
                           m_out_q.push_back(v | ((n == m_len) ? 32'h10000 : 0));
                        end
                  end else begin
                     for (int i = 0; i < r; i++)
                        for (int q = 0; q < m_cols; q++) begin
                           n++;
                           v = m_in_buf[r * perm(m_cols, q) + i];
                           m_out_q.push_back(v | ((n == m_len) ? 32'h10000 : 0));
                        end
                  end
                  m_nblk++;
                  m_in_buf.delete();
               end
            end
         end
      end
   end

   // ---------------- per-cycle comparison ----------------
   task automatic cmp(input string what, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s act=%0h exp=%0h t=%0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         cmp("in_ready", int'(in_ready), int'(m_nblk < 2));
         cmp("out_valid", int'(out_valid), int'(m_nblk > 0));     // R6
         cmp("cfg_error", int'(cfg_error), int'(m_err));           // R7
         if (m_nblk > 0 && out_valid) begin
            cmp("out_data", int'(out_data), m_out_q[0] & 'hFF);     // R3 R4
            cmp("out_last", int'(out_last), (m_out_q[0] >> 16) & 1); // R10
         end else begin
            cmp("out_last_idle", int'(out_last), 0);
         end
      end
   end

   // output back-pressure driver
   initial begin
      forever begin
         @(posedge clk);
         #1;
         out_ready = bp_mode ? (($urandom % 3) != 0) : 1'b1;
      end
   end

   // ---------------- stimulus ----------------
   task automatic do_reset();
      @(posedge clk);
      #1;
      rst_n    = 1'b0;
      in_valid = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      // R13: reset state
      cur_req = "R13";
      cmp("reset in_ready", int'(in_ready), 1);
      cmp("reset out_valid", int'(out_valid), 0);
      cmp("reset cfg_error", int'(cfg_error), 0);
      @(posedge clk);
      #1;
   endtask

   task automatic send_block(input int span, input logic [1:0] dir, input int len,
                             input int nsym, input int seed, input bit scramble);
      for (int k = 0; k < nsym; k++) begin
         if (k == 0) begin
            cfg_span = 7'(span);
            cfg_dir  = dir;
            cfg_len  = LEN_W'(len);
         end
         in_valid = 1'b1;
         in_data  = DATA_W'(seed + k * 7 + k / 5);
         @(negedge clk);
         while (!in_ready) @(negedge clk);
         @(posedge clk);
         #1;
         if (scramble) begin   // R11: ports changed mid-block
            cfg_span = 7'd40;
            cfg_dir  = (dir == 2'b01) ? 2'b11 : 2'b01;
            cfg_len  = LEN_W'(8);
         end
      end
      in_valid = 1'b0;
   endtask

   task automatic drain();
      while (m_nblk > 0) @(negedge clk);
      @(posedge clk);
      #1;
   endtask

   initial begin
      do_reset();

      // R2: single column pass-through, both directions
      cur_req = "R2";
      send_block(10, 2'b01, 12, 12, 3, 0);
      send_block(10, 2'b11, 7, 7, 40, 0);
      drain();

      // R1 R3: forward with 2, 4 and 8 columns
      cur_req = "R3";
      send_block(20, 2'b01, 16, 16, 5, 0);
      send_block(40, 2'b01, 16, 16, 9, 0);
      send_block(80, 2'b01, 24, 24, 17, 0);
      drain();

      // R1 R4 R5: inverse with 2, 4 and 8 columns
      cur_req = "R4";
      send_block(20, 2'b11, 10, 10, 60, 0);
      send_block(40, 2'b11, 20, 20, 70, 0);
      send_block(80, 2'b11, 32, 32, 80, 0);
      drain();

      // R8: largest block, eight columns, both directions
      cur_req = "R8";
      send_block(80, 2'b01, MAX_LEN, MAX_LEN, 100, 0);
      send_block(80, 2'b11, MAX_LEN, MAX_LEN, 110, 0);
      drain();

      // R9 R10 R12: back-to-back blocks under output back-pressure
      cur_req = "R9";
      bp_mode = 1'b1;
      send_block(40, 2'b01, 8, 8, 120, 0);
      send_block(20, 2'b11, 6, 6, 130, 0);
      send_block(80, 2'b01, 16, 16, 140, 0);
      send_block(10, 2'b11, 3, 3, 150, 0);
      cur_req = "R12";
      send_block(80, 2'b11, 40, 40, 160, 0);
      drain();
      bp_mode = 1'b0;

      // R11: configuration ports change during a block
      cur_req = "R11";
      send_block(80, 2'b01, 16, 16, 170, 1);
      send_block(20, 2'b11, 12, 12, 180, 1);
      drain();

      // R7 R1: unsupported span
      do_reset();
      cur_req = "R7";
      send_block(30, 2'b01, 8, 4, 1, 0);
      repeat (4) @(posedge clk);
      #1;
      send_block(20, 2'b01, 4, 4, 2, 0);   // still processed, error stays set
      drain();

      // R5: unsupported direction codes
      do_reset();
      cur_req = "R5";
      send_block(40, 2'b00, 8, 3, 1, 0);
      do_reset();
      cur_req = "R5";
      send_block(40, 2'b10, 8, 3, 1, 0);
      repeat (4) @(posedge clk);
      #1;

      // R8: zero length, non-multiple length, oversized length
      do_reset();
      cur_req = "R8";
      send_block(20, 2'b01, 0, 3, 1, 0);
      do_reset();
      cur_req = "R8";
      send_block(80, 2'b01, 12, 5, 1, 0);
      do_reset();
      cur_req = "R8";
      send_block(10, 2'b11, MAX_LEN + 8, 4, 1, 0);
      repeat (6) @(posedge clk);
      #1;

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         finished = 1'b1;
         n_bad++;
         $display("FAIL watchdog act=hung exp=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule